// File: doc/BRIEF.md
# Timer Capture Trigger Selector

This block snapshots a free-running up-counter when a chosen input transition occurs. The trigger can come from one of two sources. The first is a single dedicated capture pin. The second is the pair of count and direction inputs belonging to a neighbouring timer.

A one-bit source select picks the source. A two-bit mode field picks which transitions qualify. When a qualifying transition arrives, the current count is copied into a capture register and an interrupt request flag is set. The flag stays set until software clears it.

For the pin source, the block looks at plain rising or falling edges. For the input pair in the single-direction modes, it looks at the parity (XOR) of the two inputs rather than at either pin alone. All three inputs are asynchronous to the clock and pass through a synchronizer before any edge is judged.

Top module: `cap_trigger_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, the count, the capture register and the interrupt flag are all zero.
- R2: The count rises by exactly one every clock cycle and wraps from its maximum value to zero.
- R3: With mode 2'b00, no transition on any input changes the capture register or sets the flag, for either source.
- R4: With source 0 and mode 2'b01, a 0-to-1 change of the capture pin triggers a capture, and a 1-to-0 change does not.
- R5: With source 0 and mode 2'b10, a 1-to-0 change of the capture pin triggers a capture, and a 0-to-1 change does not.
- R6: With source 0 and mode 2'b11, every change of the capture pin triggers a capture.
- R7: With source 1 and mode 2'b01, a capture occurs only when the XOR of the count and direction inputs changes from 0 to 1.
- R8: With source 1 and mode 2'b10, a capture occurs only when the XOR of the count and direction inputs changes from 1 to 0.
- R9: With source 1 and mode 2'b11, any change of either input of the pair triggers a capture, including both inputs changing in the same sample.
- R10: With source 1 and mode 2'b01 or 2'b10, if both pair inputs change in the same sample (XOR unchanged), no capture occurs.
- R11: An input change applied before clock edge k is seen by the trigger logic after edge k+1. At edge k+2 the capture register loads the count value held between edges k+1 and k+2, and the flag is set at that same edge. The capture register holds its value on every cycle without a trigger.
- R12: The interrupt flag stays at 1 until a cycle with the clear input high. A clear in the same cycle as a new trigger leaves the flag at 1.
- R13: The source that is not selected has no effect: pair changes are ignored with source 0, and capture-pin changes are ignored with source 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Trigger source: 0 capture pin, 1 count/direction pair |
| trig_mode | input | 2 | 00 off, 01 rising / parity 0-to-1, 10 falling / parity 1-to-0, 11 any change |
| cap_pin | input | 1 | Dedicated capture pin (asynchronous) |
| cnt_in | input | 1 | Neighbouring timer count input (asynchronous) |
| dir_in | input | 1 | Neighbouring timer direction input (asynchronous) |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| count_out | output | TIMER_W | Free-running counter value |
| capture_out | output | TIMER_W | Last captured count |
| irq | output | 1 | Capture interrupt request flag |

## Verification
The bench aims at the pair-source cases where parity and pin edges disagree:
- A change of the pair that moves the XOR from 1 to 0 under the rising mode must not capture.
- A simultaneous flip of both inputs must capture only in the any-change mode.
- A design that watched a single pin instead of the parity would capture on the wrong transitions, and one that ignored simultaneous flips would miss the any-change capture.

The captured value is compared against the count seen in one exact cycle, so an extra or missing synchronizer stage shows up as an off-by-one capture. The bench also checks that the register does not update early. A clear that coincides with a trigger must leave the flag set; a design that gave the clear priority would lose that request.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_ANY  = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic pin;
        logic cnt;
        logic dir;
    } cap_in_t;

    localparam int CAP_IN_W = $bits(cap_in_t);

    // Pick the qualifying condition for the selected mode.
    function automatic logic trig_eval(input trig_mode_e mode,
                                       input logic up,
                                       input logic down,
                                       input logic any);
        logic hit;
        unique case (mode)
            TRIG_RISE: hit = up;
            TRIG_FALL: hit = down;
            TRIG_ANY:  hit = any;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= stage_q[STAGES-1];
    end

    assign q_cur = stage_q[STAGES-1];

endmodule

// File: rtl/cap_edge_sel.sv
module cap_edge_sel
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       src_sel,
    input  trig_mode_e mode,
    input  cap_in_t    cur,
    input  cap_in_t    prev,
    output logic       trig
);
    logic pin_up, pin_dn, pin_any;
    logic par_cur, par_prev, par_up, par_dn, pair_any;

    always_comb begin
        pin_up   = cur.pin & ~prev.pin;
        pin_dn   = ~cur.pin & prev.pin;
        pin_any  = cur.pin ^ prev.pin;
        par_cur  = cur.cnt ^ cur.dir;
        par_prev = prev.cnt ^ prev.dir;
        par_up   = par_cur & ~par_prev;
        par_dn   = ~par_cur & par_prev;
        pair_any = (cur.cnt ^ prev.cnt) | (cur.dir ^ prev.dir);
    end

    assign trig = src_sel ? trig_eval(mode, par_up, par_dn, pair_any)
                          : trig_eval(mode, pin_up, pin_dn, pin_any);

    // R10: unchanged parity never triggers in the directional modes
    assert_parity_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (src_sel && (mode == TRIG_RISE || mode == TRIG_FALL) &&
         ((cur.cnt ^ cur.dir) == (prev.cnt ^ prev.dir))) |-> !trig);

    // R13: pair inputs alone cannot trigger while the pin is selected
    assert_pin_only_R13: assert property (@(posedge clk) disable iff (rst)
        (!src_sel && cur.pin == prev.pin) |-> !trig);

endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic               irq_clr,
    output logic [TIMER_W-1:0] count,
    output logic [TIMER_W-1:0] capture,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       capture <= '0;
        else if (trig) capture <= count;
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (trig)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1);

    assert_capture_load_R11: assert property (@(posedge clk) disable iff (rst)
        trig |=> capture == $past(count));

    assert_capture_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(capture));

    assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    assert_irq_setwins_R12: assert property (@(posedge clk) disable iff (rst)
        trig |=> irq);

endmodule

// File: rtl/cap_trigger_unit.sv
module cap_trigger_unit
    import cap_pkg::*;
#(
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_sel,
    input  logic [1:0]         trig_mode,
    input  logic               cap_pin,
    input  logic               cnt_in,
    input  logic               dir_in,
    input  logic               irq_clr,
    output logic [TIMER_W-1:0] count_out,
    output logic [TIMER_W-1:0] capture_out,
    output logic               irq
);
    trig_mode_e mode_e;
    cap_in_t    raw_in, smp_cur, smp_prev;
    logic       trig;

    assign mode_e = trig_mode_e'(trig_mode);
    assign raw_in = '{pin: cap_pin, cnt: cnt_in, dir: dir_in};

    cap_sync #(.W(CAP_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (raw_in),
        .q_cur  (smp_cur),
        .q_prev (smp_prev)
    );

    cap_edge_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .mode    (mode_e),
        .cur     (smp_cur),
        .prev    (smp_prev),
        .trig    (trig)
    );

    cap_store #(.TIMER_W(TIMER_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .irq_clr (irq_clr),
        .count   (count_out),
        .capture (capture_out),
        .irq     (irq)
    );

    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (trig_mode == 2'b00) |-> !trig);

endmodule

// File: tb/tb_cap_trigger_unit.sv
module tb_cap_trigger_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         src_sel = 1'b0;
    logic [1:0]   trig_mode = 2'b00;
    logic         cap_pin = 1'b0, cnt_in = 1'b0, dir_in = 1'b0;
    logic         irq_clr = 1'b0;
    logic [W-1:0] count_out, capture_out;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cap_trigger_unit #(.TIMER_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .trig_mode(trig_mode),
        .cap_pin(cap_pin), .cnt_in(cnt_in), .dir_in(dir_in), .irq_clr(irq_clr),
        .count_out(count_out), .capture_out(capture_out), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic s, input logic [1:0] m);
        @(negedge clk);
        src_sel   = s;
        trig_mode = m;
    endtask

    // Drive new input levels and confirm capture (or its absence).
    task automatic stim(input logic p, input logic c, input logic d,
                        input bit exp_cap, input string req);
        logic [W-1:0] old_cap, exp_val;
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        old_cap = capture_out;
        cap_pin = p; cnt_in = c; dir_in = d;
        @(negedge clk);
        @(negedge clk);
        exp_val = count_out;
        if (exp_cap)
            chk(capture_out == old_cap, "R11 no early load", capture_out, old_cap);
        @(negedge clk);
        if (exp_cap) begin
            chk(capture_out == exp_val, req, capture_out, exp_val);
            chk(irq == 1'b1, req, irq, 1);
        end else begin
            chk(capture_out == old_cap, req, capture_out, old_cap);
            chk(irq == 1'b0, req, irq, 0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(count_out == 0, "R1 count", count_out, 0);
        chk(capture_out == 0, "R1 capture", capture_out, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(count_out == 1, "R1 first count", count_out, 1);
    endtask

    task automatic t_count;
        logic [W-1:0] a;
        a = count_out;
        @(negedge clk);
        chk(count_out == W'(a + 1), "R2 step", count_out, int'(W'(a + 1)));
        for (int i = 0; i < 600 && count_out != {W{1'b1}}; i++) @(negedge clk);
        @(negedge clk);
        chk(count_out == 0, "R2 wrap", count_out, 0);
    endtask

    task automatic t_off;
        set_cfg(1'b0, 2'b00);
        stim(1, 0, 0, 0, "R3 pin rise off");
        stim(0, 0, 0, 0, "R3 pin fall off");
        set_cfg(1'b1, 2'b00);
        stim(0, 1, 0, 0, "R3 pair off");
        stim(0, 0, 0, 0, "R3 pair back off");
    endtask

    task automatic t_pin;
        set_cfg(1'b0, 2'b01);
        stim(1, 0, 0, 1, "R4 rise");
        stim(0, 0, 0, 0, "R4 fall ignored");
        set_cfg(1'b0, 2'b10);
        stim(1, 0, 0, 0, "R5 rise ignored");
        stim(0, 0, 0, 1, "R5 fall");
        set_cfg(1'b0, 2'b11);
        stim(1, 0, 0, 1, "R6 rise");
        stim(0, 0, 0, 1, "R6 fall");
        stim(0, 1, 0, 0, "R13 pair ignored");
        stim(0, 1, 1, 0, "R13 pair ignored");
        stim(0, 0, 0, 0, "R13 pair ignored");
    endtask

    task automatic t_pair;
        set_cfg(1'b1, 2'b01);
        stim(0, 1, 0, 1, "R7 parity up");
        stim(0, 1, 1, 0, "R7 parity down ignored");
        stim(0, 0, 1, 1, "R7 parity up dir");
        stim(0, 1, 0, 0, "R10 both flip rise");
        stim(1, 1, 0, 0, "R13 pin ignored");
        stim(0, 1, 0, 0, "R13 pin ignored");
        set_cfg(1'b1, 2'b10);
        stim(0, 1, 1, 1, "R8 parity down");
        stim(0, 0, 1, 0, "R8 parity up ignored");
        stim(0, 1, 0, 0, "R10 both flip fall");
        stim(0, 0, 0, 1, "R8 parity down cnt");
        set_cfg(1'b1, 2'b11);
        stim(0, 1, 1, 1, "R9 both flip any");
        stim(0, 1, 0, 1, "R9 dir only");
        stim(0, 0, 0, 1, "R9 cnt only");
    endtask

    task automatic t_irq;
        set_cfg(1'b0, 2'b01);
        stim(1, 0, 0, 1, "R12 set");
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(irq == 1'b1, "R12 sticky", irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R12 clear", irq, 0);
        cap_pin = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b1, "R12 set wins over clear", irq, 1);
    endtask

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_count();
        t_off();
        t_pin();
        t_pair();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule